// File: doc/BRIEF.md
# DMA Channel Configuration Register File

This block is the processor-facing configuration store of a four-channel DMA controller. Each channel has five 32-bit registers: primary control, secondary control, source address, destination address and transfer count. The processor reaches them over a 32-bit peripheral bus, one register per access. A register is selected by its address alone. The upper address bits name the channel and the lower three bits name the register within it. Every access takes a fixed number of cycles. The end of an access is marked by a one-cycle done strobe, and read data is valid in that cycle.

Each channel also holds two synchronization latches, one for the read side and one for the write side. The transfer engine sees them as pending flags. A latch is set by an external event pulse or by the processor writing a one to its status bit in the secondary control register. It is cleared by the processor writing a one to the paired clear bit, or by the transfer engine reporting that the action the event started has completed. All register contents are driven out continuously so the transfer engine can use them.

Top module: `dmacfg_regfile`

## Requirements
- R1: The register address is {channel, offset}. Offset 0 is primary control, 1 is secondary control, 2 is source, 3 is destination and 4 is transfer count. A written value reads back unchanged and appears on the matching output slice. For secondary control this holds for bits 31:4.
- R2: An accepted request raises `done` for exactly one cycle, LAT cycles after the request cycle, with the request cycle counted as the first. With LAT=5, `done` is high in the fifth cycle. A write takes effect at the edge that raises `done`. On a read, `rdata` holds the register value during the `done` cycle.
- R3: Only one access is outstanding at a time. A request presented while an access is in progress is ignored. A request presented in the `done` cycle is accepted.
- R4: Offsets 5, 6 and 7 of any channel read as zero, and writes to them change nothing.
- R5: In secondary control, bit 0 is the read-sync status, bit 1 the read-sync clear, bit 2 the write-sync status and bit 3 the write-sync clear. Status bits read back the latch state. Clear bits always read 0.
- R6: An event pulse on `rsync_evt[i]` or `wsync_evt[i]` sets the matching latch. The matching pending output is high from the next cycle.
- R7: Writing 1 to a status bit sets that latch. Writing 0 to a status or clear bit leaves the latch as it was. A set latch stays set until it is cleared.
- R8: Writing 1 to a clear bit clears the matching latch and leaves the other latch untouched.
- R9: A pulse on `rsync_fin[i]` or `wsync_fin[i]` clears the matching latch from the next cycle.
- R10: When a set and a clear reach the same latch at the same edge, the clear wins.
- R11: Synchronous active-high reset zeroes every register, every latch, `rdata` and `done`. An access that was in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request |
| req_addr | input | 5 | Register address {channel, offset} |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsync_evt | input | 4 | Read-sync event pulse per channel |
| wsync_evt | input | 4 | Write-sync event pulse per channel |
| rsync_fin | input | 4 | Read-sync action completed, per channel |
| wsync_fin | input | 4 | Write-sync action completed, per channel |
| rdata | output | 32 | Read data, valid with done |
| done | output | 1 | Access complete strobe |
| pri_ctl | output | 128 | Primary control, channel i at bits [32i+31:32i] |
| sec_ctl | output | 128 | Secondary control with live status bits |
| src_addr | output | 128 | Source address per channel |
| dst_addr | output | 128 | Destination address per channel |
| xfer_cnt | output | 128 | Transfer count per channel |
| rsync_pend | output | 4 | Read-sync pending flag per channel |
| wsync_pend | output | 4 | Write-sync pending flag per channel |

## Verification
The bench holds a request high across a whole access with a different address. A design that accepted requests while busy would corrupt a second register. It also issues a request in the `done` cycle; a design that stalled there would lose the back-to-back write. Event pulses are made to coincide with completion pulses and with a processor clear, to catch a design that gives the set priority and leaves a latch stuck pending. Zero writes to status and clear bits, and writes to unmapped offsets, are then checked for a latch that drops, a register aliased onto an unmapped offset, or a clear bit that reads back as 1.

// File: rtl/dmacfg_pkg.sv
package dmacfg_pkg;

    localparam int OFF_W       = 3;
    localparam int REGS_PER_CH = 5;

    typedef enum logic [OFF_W-1:0] {
        OFF_PRI = 3'd0,
        OFF_SEC = 3'd1,
        OFF_SRC = 3'd2,
        OFF_DST = 3'd3,
        OFF_CNT = 3'd4
    } cfg_off_e;

    localparam int SEC_RSTAT     = 0;
    localparam int SEC_RCLR      = 1;
    localparam int SEC_WSTAT     = 2;
    localparam int SEC_WCLR      = 3;
    localparam int SEC_FLAG_BITS = 4;

endpackage

// File: rtl/dmacfg_access.sv
module dmacfg_access #(
    parameter int ADDR_W = 5,
    parameter int XLEN   = 32,
    parameter int LAT    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [XLEN-1:0]   req_wdata,
    output logic              commit,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic              cmt_we,
    output logic [XLEN-1:0]   cmt_wdata,
    output logic              done
);

    localparam int               CNT_W = $clog2(LAT);
    localparam logic [CNT_W-1:0] LOAD  = CNT_W'(LAT - 2);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [XLEN-1:0]   wdata;
        logic              done;
    } acc_t;

    acc_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.cnt == '0) begin
            if (req_valid) begin
                s_d.cnt   = LOAD;
                s_d.addr  = req_addr;
                s_d.we    = req_we;
                s_d.wdata = req_wdata;
            end
        end else begin
            s_d.cnt = s_q.cnt - LAST;
            if (s_q.cnt == LAST) begin
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign commit    = (s_q.cnt == LAST);
    assign cmt_addr  = s_q.addr;
    assign cmt_we    = s_q.we;
    assign cmt_wdata = s_q.wdata;
    assign done      = s_q.done;

endmodule

// File: rtl/dmacfg_chan.sv
module dmacfg_chan
    import dmacfg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             rs_evt,
    input  logic             ws_evt,
    input  logic             rs_fin,
    input  logic             ws_fin,
    output logic [XLEN-1:0]  pri_o,
    output logic [XLEN-1:0]  sec_o,
    output logic [XLEN-1:0]  src_o,
    output logic [XLEN-1:0]  dst_o,
    output logic [XLEN-1:0]  cnt_o,
    output logic             rs_pend,
    output logic             ws_pend
);

    localparam int HI_W = XLEN - SEC_FLAG_BITS;

    typedef struct packed {
        logic [XLEN-1:0] pri;
        logic [HI_W-1:0] sec_hi;
        logic [XLEN-1:0] src;
        logic [XLEN-1:0] dst;
        logic [XLEN-1:0] cnt;
        logic            rs;
        logic            ws;
    } chan_t;

    chan_t s_d, s_q;
    logic  sec_wr;
    logic  rs_set, rs_clr, ws_set, ws_clr;

    always_comb begin
        s_d    = s_q;
        sec_wr = wr_en && (wr_off == OFF_SEC);
        if (wr_en) begin
            case (cfg_off_e'(wr_off))
                OFF_PRI: s_d.pri    = wr_data;
                OFF_SEC: s_d.sec_hi = wr_data[XLEN-1:SEC_FLAG_BITS];
                OFF_SRC: s_d.src    = wr_data;
                OFF_DST: s_d.dst    = wr_data;
                OFF_CNT: s_d.cnt    = wr_data;
                default: ;
            endcase
        end
        rs_set = rs_evt || (sec_wr && wr_data[SEC_RSTAT]);
        rs_clr = rs_fin || (sec_wr && wr_data[SEC_RCLR]);
        ws_set = ws_evt || (sec_wr && wr_data[SEC_WSTAT]);
        ws_clr = ws_fin || (sec_wr && wr_data[SEC_WCLR]);
        s_d.rs = !rs_clr && (rs_set || s_q.rs);
        s_d.ws = !ws_clr && (ws_set || s_q.ws);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        sec_o                          = '0;
        sec_o[XLEN-1:SEC_FLAG_BITS]    = s_q.sec_hi;
        sec_o[SEC_RSTAT]               = s_q.rs;
        sec_o[SEC_WSTAT]               = s_q.ws;
    end

    assign pri_o   = s_q.pri;
    assign src_o   = s_q.src;
    assign dst_o   = s_q.dst;
    assign cnt_o   = s_q.cnt;
    assign rs_pend = s_q.rs;
    assign ws_pend = s_q.ws;

endmodule

// File: rtl/dmacfg_rdmux.sv
module dmacfg_rdmux
    import dmacfg_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int XLEN = 32,
    parameter int CH_W = 2
) (
    input  logic [NCH*XLEN-1:0] pri_all,
    input  logic [NCH*XLEN-1:0] sec_all,
    input  logic [NCH*XLEN-1:0] src_all,
    input  logic [NCH*XLEN-1:0] dst_all,
    input  logic [NCH*XLEN-1:0] cnt_all,
    input  logic [CH_W-1:0]     ch,
    input  logic [OFF_W-1:0]    off,
    output logic [XLEN-1:0]     value
);

    always_comb begin
        value = '0;
        if (int'(ch) < NCH) begin
            case (cfg_off_e'(off))
                OFF_PRI: value = pri_all[ch*XLEN +: XLEN];
                OFF_SEC: value = sec_all[ch*XLEN +: XLEN];
                OFF_SRC: value = src_all[ch*XLEN +: XLEN];
                OFF_DST: value = dst_all[ch*XLEN +: XLEN];
                OFF_CNT: value = cnt_all[ch*XLEN +: XLEN];
                default: value = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmacfg_regfile.sv
module dmacfg_regfile
    import dmacfg_pkg::*;
#(
    parameter  int NCH    = 4,
    parameter  int XLEN   = 32,
    parameter  int LAT    = 5,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = CH_W + OFF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_we,
    input  logic [XLEN-1:0]     req_wdata,
    input  logic [NCH-1:0]      rsync_evt,
    input  logic [NCH-1:0]      wsync_evt,
    input  logic [NCH-1:0]      rsync_fin,
    input  logic [NCH-1:0]      wsync_fin,
    output logic [XLEN-1:0]     rdata,
    output logic                done,
    output logic [NCH*XLEN-1:0] pri_ctl,
    output logic [NCH*XLEN-1:0] sec_ctl,
    output logic [NCH*XLEN-1:0] src_addr,
    output logic [NCH*XLEN-1:0] dst_addr,
    output logic [NCH*XLEN-1:0] xfer_cnt,
    output logic [NCH-1:0]      rsync_pend,
    output logic [NCH-1:0]      wsync_pend
);

    logic              commit;
    logic [ADDR_W-1:0] cmt_addr;
    logic              cmt_we;
    logic [XLEN-1:0]   cmt_wdata;
    logic [CH_W-1:0]   cmt_ch;
    logic [OFF_W-1:0]  cmt_off;
    logic [XLEN-1:0]   rd_val;
    logic [XLEN-1:0]   rd_d, rd_q;

    assign cmt_ch  = cmt_addr[ADDR_W-1:OFF_W];
    assign cmt_off = cmt_addr[OFF_W-1:0];

    dmacfg_access #(
        .ADDR_W (ADDR_W),
        .XLEN   (XLEN),
        .LAT    (LAT)
    ) u_access (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .commit    (commit),
        .cmt_addr  (cmt_addr),
        .cmt_we    (cmt_we),
        .cmt_wdata (cmt_wdata),
        .done      (done)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic wr_en;
        assign wr_en = commit && cmt_we && (cmt_ch == CH_W'(g));

        dmacfg_chan #(
            .XLEN (XLEN)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_off  (cmt_off),
            .wr_data (cmt_wdata),
            .rs_evt  (rsync_evt[g]),
            .ws_evt  (wsync_evt[g]),
            .rs_fin  (rsync_fin[g]),
            .ws_fin  (wsync_fin[g]),
            .pri_o   (pri_ctl[g*XLEN +: XLEN]),
            .sec_o   (sec_ctl[g*XLEN +: XLEN]),
            .src_o   (src_addr[g*XLEN +: XLEN]),
            .dst_o   (dst_addr[g*XLEN +: XLEN]),
            .cnt_o   (xfer_cnt[g*XLEN +: XLEN]),
            .rs_pend (rsync_pend[g]),
            .ws_pend (wsync_pend[g])
        );
    end

    dmacfg_rdmux #(
        .NCH  (NCH),
        .XLEN (XLEN),
        .CH_W (CH_W)
    ) u_rdmux (
        .pri_all (pri_ctl),
        .sec_all (sec_ctl),
        .src_all (src_addr),
        .dst_all (dst_addr),
        .cnt_all (xfer_cnt),
        .ch      (cmt_ch),
        .off     (cmt_off),
        .value   (rd_val)
    );

    always_comb begin
        rd_d = rd_q;
        if (commit) begin
            rd_d = cmt_we ? '0 : rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/dmacfg_regfile_chk.sv
module dmacfg_regfile_chk #(
    parameter int NCH  = 4,
    parameter int XLEN = 32,
    parameter int LAT  = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            done,
    input logic [XLEN-1:0] rdata,
    input logic [NCH-1:0]  rsync_evt,
    input logic [NCH-1:0]  wsync_evt,
    input logic [NCH-1:0]  rsync_fin,
    input logic [NCH-1:0]  wsync_fin,
    input logic [NCH-1:0]  rsync_pend,
    input logic [NCH-1:0]  wsync_pend
);

    localparam int            TW   = $clog2(LAT + 1);
    localparam logic [TW-1:0] TEND = TW'(LAT - 1);

    logic [TW-1:0] tc;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc <= '0;
        end else if (tc == '0 || done) begin
            tc <= req_valid ? TW'(1) : '0;
        end else begin
            tc <= tc + TW'(1);
        end
    end

    a_r2_done_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (tc == TEND));

    a_r3_done_on_time: assert property (@(posedge clk) disable iff (rst)
        (tc == TEND) |-> done);

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_reset_state: assert property (@(posedge clk)
        rst |=> (rsync_pend == '0 && wsync_pend == '0 && !done && rdata == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        a_r9_rfin_clears: assert property (@(posedge clk) disable iff (rst)
            rsync_fin[i] |=> !rsync_pend[i]);

        a_r9_wfin_clears: assert property (@(posedge clk) disable iff (rst)
            wsync_fin[i] |=> !wsync_pend[i]);

        a_r6_revt_sets: assert property (@(posedge clk) disable iff (rst)
            (rsync_evt[i] && !rsync_fin[i]) |=> (rsync_pend[i] || done));

        a_r6_wevt_sets: assert property (@(posedge clk) disable iff (rst)
            (wsync_evt[i] && !wsync_fin[i]) |=> (wsync_pend[i] || done));

        a_r7_rpend_holds: assert property (@(posedge clk) disable iff (rst)
            (rsync_pend[i] && !rsync_fin[i]) |=> (rsync_pend[i] || done));

        a_r7_wpend_holds: assert property (@(posedge clk) disable iff (rst)
            (wsync_pend[i] && !wsync_fin[i]) |=> (wsync_pend[i] || done));
    end

endmodule

bind dmacfg_regfile dmacfg_regfile_chk #(
    .NCH  (NCH),
    .XLEN (XLEN),
    .LAT  (LAT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .done       (done),
    .rdata      (rdata),
    .rsync_evt  (rsync_evt),
    .wsync_evt  (wsync_evt),
    .rsync_fin  (rsync_fin),
    .wsync_fin  (wsync_fin),
    .rsync_pend (rsync_pend),
    .wsync_pend (wsync_pend)
);

// File: tb/dmacfg_regfile_bench.sv
module dmacfg_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int XLEN       = 32;
    localparam int LAT        = 5;
    localparam int ADDR_W     = 5;

    logic              clk       = 1'b0;
    logic              rst       = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic              req_we    = 1'b0;
    logic [XLEN-1:0]   req_wdata = '0;
    logic [NCH-1:0]    rsync_evt = '0;
    logic [NCH-1:0]    wsync_evt = '0;
    logic [NCH-1:0]    rsync_fin = '0;
    logic [NCH-1:0]    wsync_fin = '0;

    logic [XLEN-1:0]     rdata;
    logic                done;
    logic [NCH*XLEN-1:0] pri_ctl, sec_ctl, src_addr, dst_addr, xfer_cnt;
    logic [NCH-1:0]      rsync_pend, wsync_pend;

    int    n_chk    = 0;
    int    n_fail   = 0;
    string cur_req  = "R11";
    bit    finished = 1'b0;
    bit    started  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmacfg_regfile #(
        .NCH  (NCH),
        .XLEN (XLEN),
        .LAT  (LAT)
    ) u_dmacfg_regfile (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_we     (req_we),
        .req_wdata  (req_wdata),
        .rsync_evt  (rsync_evt),
        .wsync_evt  (wsync_evt),
        .rsync_fin  (rsync_fin),
        .wsync_fin  (wsync_fin),
        .rdata      (rdata),
        .done       (done),
        .pri_ctl    (pri_ctl),
        .sec_ctl    (sec_ctl),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .xfer_cnt   (xfer_cnt),
        .rsync_pend (rsync_pend),
        .wsync_pend (wsync_pend)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_reg [NCH][5];
    bit          m_rp [NCH];
    bit          m_wp [NCH];
    int          m_busy;
    int          m_ch, m_off;
    bit          m_we;
    logic [31:0] m_wdata;
    bit          m_done;
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_view(int ch, int off);
        if (off > 4) return 32'h0;
        if (off == 1) return (m_reg[ch][1] & ~32'hF) | (32'(m_wp[ch]) << 2) | 32'(m_rp[ch]);
        return m_reg[ch][off];
    endfunction

    always @(posedge clk) begin : mdl
        bit fin_now;
        started = 1'b1;
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                for (int r = 0; r < 5; r++) m_reg[c][r] = 32'h0;
                m_rp[c] = 1'b0;
                m_wp[c] = 1'b0;
            end
            m_busy  = 0;
            m_done  = 1'b0;
            m_rdata = 32'h0;
        end else begin
            fin_now = (m_busy == 1);
            if (fin_now) m_rdata = m_we ? 32'h0 : m_view(m_ch, m_off);
            for (int c = 0; c < NCH; c++) begin
                bit hit, sr, cr, sw, cw;
                hit = fin_now && m_we && (c == m_ch) && (m_off == 1);
                sr  = rsync_evt[c] || (hit && m_wdata[0]);
                cr  = rsync_fin[c] || (hit && m_wdata[1]);
                sw  = wsync_evt[c] || (hit && m_wdata[2]);
                cw  = wsync_fin[c] || (hit && m_wdata[3]);
                m_rp[c] = cr ? 1'b0 : (sr ? 1'b1 : m_rp[c]);
                m_wp[c] = cw ? 1'b0 : (sw ? 1'b1 : m_wp[c]);
            end
            if (fin_now && m_we && m_off < 5) m_reg[m_ch][m_off] = m_wdata;
            m_done = fin_now;
            if (m_busy == 0) begin
                if (req_valid) begin
                    m_ch    = int'(req_addr) / 8;
                    m_off   = int'(req_addr) % 8;
                    m_we    = req_we;
                    m_wdata = req_wdata;
                    m_busy  = LAT - 2;
                end
            end else begin
                m_busy = m_busy - 1;
            end
        end
    end

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    // compare against the reference on every clock, away from the edge
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(cur_req, "done", 32'(done), 32'(m_done));
            chk(cur_req, "rdata", rdata, m_rdata);
            for (int c = 0; c < NCH; c++) begin
                chk(cur_req, "pri_ctl", pri_ctl[c*XLEN +: XLEN], m_reg[c][0]);
                chk(cur_req, "sec_ctl", sec_ctl[c*XLEN +: XLEN], m_view(c, 1));
                chk(cur_req, "src_addr", src_addr[c*XLEN +: XLEN], m_reg[c][2]);
                chk(cur_req, "dst_addr", dst_addr[c*XLEN +: XLEN], m_reg[c][3]);
                chk(cur_req, "xfer_cnt", xfer_cnt[c*XLEN +: XLEN], m_reg[c][4]);
                chk(cur_req, "rsync_pend", 32'(rsync_pend[c]), 32'(m_rp[c]));
                chk(cur_req, "wsync_pend", 32'(wsync_pend[c]), 32'(m_wp[c]));
            end
        end
    end

    function automatic logic [31:0] pat(int ch, int off);
        return 32'h5A00_0040 | (32'(ch) << 16) | (32'(off) << 8);
    endfunction

    task automatic acc(input bit we, input int ch, input int off, input logic [31:0] d,
                       output logic [31:0] rd, output int cycles);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = ADDR_W'(ch * 8 + off);
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        cycles    = 2;
        while (!done && cycles < 50) begin
            @(negedge clk);
            cycles++;
        end
        rd = rdata;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL %s watchdog: actual hung expected finish", cur_req);
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        int          cyc;
        int          seen;

        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11", "reset done", 32'(done), 32'h0);
        chk("R11", "reset rdata", rdata, 32'h0);
        chk("R11", "reset pend", {24'h0, rsync_pend, wsync_pend}, 32'h0);
        chk("R11", "reset pri_ctl", pri_ctl[31:0], 32'h0);
        rst = 1'b0;

        // R1: full map, R2: latency
        cur_req = "R1";
        for (int c = 0; c < NCH; c++)
            for (int o = 0; o < 5; o++) acc(1'b1, c, o, pat(c, o), rd, cyc);
        for (int c = 0; c < NCH; c++)
            for (int o = 0; o < 5; o++) begin
                acc(1'b0, c, o, 32'h0, rd, cyc);
                chk("R1", "readback", rd, pat(c, o));
                chk("R2", "latency", 32'(cyc), 32'(LAT));
            end

        // R4: unmapped offsets
        cur_req = "R4";
        acc(1'b1, 2, 5, 32'hFFFF_FFFF, rd, cyc);
        acc(1'b1, 2, 7, 32'hFFFF_FFFF, rd, cyc);
        acc(1'b0, 2, 5, 32'h0, rd, cyc);
        chk("R4", "unmapped read 5", rd, 32'h0);
        acc(1'b0, 2, 7, 32'h0, rd, cyc);
        chk("R4", "unmapped read 7", rd, 32'h0);
        chk("R4", "neighbour intact", xfer_cnt[2*XLEN +: XLEN], pat(2, 4));

        // R3: request held while busy is ignored, request in done cycle taken
        cur_req = "R3";
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = ADDR_W'(0 * 8 + 2); req_wdata = 32'h1111_2222;
        @(negedge clk);
        req_addr = ADDR_W'(1 * 8 + 3); req_wdata = 32'h3333_4444;
        seen = 0;
        while (!done && seen < 50) begin @(negedge clk); seen++; end
        req_addr = ADDR_W'(3 * 8 + 4); req_wdata = 32'h0000_0077;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "busy request ignored", dst_addr[1*XLEN +: XLEN], pat(1, 3));
        chk("R3", "first write landed", src_addr[31:0], 32'h1111_2222);
        while (!done && seen < 100) begin @(negedge clk); seen++; end
        chk("R3", "done-cycle request accepted", xfer_cnt[3*XLEN +: XLEN], 32'h0000_0077);

        // R6 / R5: hardware events and status layout
        cur_req = "R6";
        @(negedge clk); rsync_evt[1] = 1'b1;
        @(negedge clk); rsync_evt[1] = 1'b0;
        chk("R6", "rsync set by event", 32'(rsync_pend[1]), 32'h1);
        wsync_evt[3] = 1'b1;
        @(negedge clk); wsync_evt[3] = 1'b0;
        chk("R6", "wsync set by event", 32'(wsync_pend[3]), 32'h1);
        cur_req = "R5";
        acc(1'b0, 1, 1, 32'h0, rd, cyc);
        chk("R5", "sec read rstat", rd, pat(1, 1) | 32'h1);
        acc(1'b0, 3, 1, 32'h0, rd, cyc);
        chk("R5", "sec read wstat", rd, pat(3, 1) | 32'h4);

        // R8: CPU clear
        cur_req = "R8";
        acc(1'b1, 1, 1, 32'hBEE0_0002, rd, cyc);
        chk("R8", "rsync cleared", 32'(rsync_pend[1]), 32'h0);
        chk("R5", "clear bit reads 0", sec_ctl[1*XLEN +: XLEN], 32'hBEE0_0000);

        // R7: CPU set and zero writes
        cur_req = "R7";
        acc(1'b1, 2, 1, 32'h0000_0005, rd, cyc);
        chk("R7", "both set by write", {30'h0, rsync_pend[2], wsync_pend[2]}, 32'h3);
        acc(1'b1, 2, 1, 32'h0000_0000, rd, cyc);
        chk("R7", "zero write no effect", {30'h0, rsync_pend[2], wsync_pend[2]}, 32'h3);
        acc(1'b1, 2, 1, 32'h0000_0008, rd, cyc);
        chk("R8", "only wsync cleared", {30'h0, rsync_pend[2], wsync_pend[2]}, 32'h2);

        // R9: completion pulses
        cur_req = "R9";
        @(negedge clk); rsync_fin[2] = 1'b1;
        @(negedge clk); rsync_fin[2] = 1'b0;
        chk("R9", "rsync auto-cleared", 32'(rsync_pend[2]), 32'h0);
        wsync_evt[0] = 1'b1;
        @(negedge clk); wsync_evt[0] = 1'b0; wsync_fin[0] = 1'b1;
        @(negedge clk); wsync_fin[0] = 1'b0;
        chk("R9", "wsync auto-cleared", 32'(wsync_pend[0]), 32'h0);

        // R10: clear beats set
        cur_req = "R10";
        @(negedge clk); rsync_evt[0] = 1'b1; rsync_fin[0] = 1'b1;
        @(negedge clk); rsync_evt[0] = 1'b0; rsync_fin[0] = 1'b0;
        chk("R10", "fin beats event", 32'(rsync_pend[0]), 32'h0);
        wsync_evt[0] = 1'b1;
        acc(1'b1, 0, 1, 32'h0000_0008, rd, cyc);
        chk("R10", "cpu clear beats held event", 32'(wsync_pend[0]), 32'h0);
        @(negedge clk);
        chk("R6", "event sets again", 32'(wsync_pend[0]), 32'h1);
        wsync_evt[0] = 1'b0;

        // R11: reset during an access
        cur_req = "R11";
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = ADDR_W'(1 * 8 + 0); req_wdata = 32'hDEAD_BEEF;
        @(negedge clk); req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R11", "pri cleared", pri_ctl[1*XLEN +: XLEN], 32'h0);
        chk("R11", "pend cleared", {24'h0, rsync_pend, wsync_pend}, 32'h0);
        seen = 0;
        repeat (2 * LAT) begin @(negedge clk); if (done) seen++; end
        chk("R11", "dropped access no done", 32'(seen), 32'h0);
        chk("R11", "dropped write absent", pri_ctl[1*XLEN +: XLEN], 32'h0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule